// File: doc/BRIEF.md
# Nine-Bit Multi-Drop Serial Receiver

This block receives asynchronous serial frames made of a start bit, eight data bits sent least significant bit first, a ninth bit and a stop bit. An external baud generator supplies a one-cycle oversampling strobe at sixteen times the bit rate. The line is sampled on that strobe, and each bit is decided by a two-of-three vote taken around its centre. The receiver presents the byte, a ninth-bit status, a receive-complete flag, a framing-error flag and an overrun flag.

The block is built for links where several nodes share one line. In filtered mode (`mode_all` = 0), a completed frame is kept only if its ninth bit is 1. Address frames carry that 1, so every node sees them. Data frames carry a 0 and are dropped without a trace. A node that recognises its own address switches itself to unfiltered mode (`mode_all` = 1), in which it keeps every frame. In unfiltered mode an optional parity check can be switched on, and the ninth-bit status then reports a parity error instead of the raw bit.

The controller has five states. `RX_IDLE` waits for a falling edge while reception is enabled and moves to `RX_START`. `RX_START` counts to the middle of the start bit. A low vote there moves on to `RX_DATA`, and a high vote is a false start that returns to `RX_IDLE`. `RX_DATA` takes eight bits and moves to `RX_NINTH`, which takes one bit and moves to `RX_STOP`. `RX_STOP` samples the stop bit, issues the completion pulse and returns to `RX_IDLE`. From any state, a low enable or a change of `mode_all` forces `RX_IDLE`.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_flag`, `overrun`, `frame_err`, `rx_bit9` and `rx_data` are all 0, and the receiver is idle.
- R2: A frame begins at a falling edge of `rxd`. Each bit lasts 16 `tick` strobes, and the data byte arrives least significant bit first and is presented on `rx_data`.
- R3: A low pulse on `rxd` that has ended before the middle of the start bit is a false start. It sets no flag, and the receiver then accepts the next valid frame.
- R4: With `mode_all` = 0, only frames whose ninth bit is 1 are kept. Frames whose ninth bit is 0 leave `rx_data`, `rx_bit9` and `rx_flag` unchanged.
- R5: With `mode_all` = 1, every completed frame sets `rx_flag`. With `par_en` = 0, `rx_bit9` equals the received ninth bit.
- R6: With `mode_all` = 1 and `par_en` = 1, `rx_bit9` is a parity error flag: the XOR of the eight data bits, the ninth bit and `par_odd`, where `par_odd` = 0 selects even parity and 1 selects odd parity. With `mode_all` = 0, parity settings are ignored and `rx_bit9` is the raw ninth bit.
- R7: For each kept frame, `frame_err` is set to 1 if the sampled stop bit is 0 and cleared to 0 if it is 1.
- R8: While `rx_en` = 0, no reception starts. Dropping `rx_en` during a frame abandons that frame, so it sets no flag.
- R9: A change of `mode_all` during a frame abandons that frame, so it sets no flag.
- R10: `rx_flag` stays at 1 until `rx_clr` is pulsed. A kept frame that completes while `rx_flag` = 1 (and `rx_clr` = 0) sets `overrun`. `rx_clr` clears both `rx_flag` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line, idles high |
| rx_en | input | 1 | Reception enable |
| mode_all | input | 1 | 0 = keep only ninth-bit-set frames, 1 = keep all frames |
| par_en | input | 1 | Parity check enable (unfiltered mode) |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| rx_clr | input | 1 | Clears the receive and overrun flags |
| rx_data | output | 8 | Last kept data byte |
| rx_bit9 | output | 1 | Ninth bit, or parity error when checking |
| rx_flag | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Stop bit of last kept frame was 0 |
| overrun | output | 1 | A frame was kept while the flag was set |

## Verification
The abort paths are the hardest to reach from the ports. An abort leaves no mark unless the abandoned frame would otherwise have been kept, and unless the rest of the line cannot start a new reception. The bench therefore sends an all-ones byte with the ninth bit set, so the line never falls again after the start bit. It drops the enable, or flips the mode, partway through the data bits. A raised flag would then mean the frame was not abandoned. The main sweep covers both modes, both parity settings, both parity senses and both ninth-bit values over a set of byte patterns.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/mprx_sampler.sv
// Line synchronizer, edge detector and three-sample majority window.
module mprx_sampler #(
    parameter int STAGES = 2,
    parameter int VOTES  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    output logic fall,
    output logic maj
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [VOTES-1:0]  win_q;
    logic              line;

    assign line = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            win_q  <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], rxd};
            prev_q <= line;
            if (tick) win_q <= {win_q[VOTES-2:0], line};
        end
    end

    assign fall = prev_q & ~line;
    assign maj  = ($countones(win_q) > (VOTES / 2));
endmodule

// File: rtl/mprx_fsm.sv
// Frame sequencer: start qualification, bit timing and shifting.
module mprx_fsm
    import mprx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          fall,
    input  logic          maj,
    input  logic          rx_en,
    input  logic          mode_all,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] shreg,
    output logic          nine,
    output logic          stop_bit
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
    localparam int MID = OSR / 2;

    rx_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic          mode_d;
    logic          abort, last, midp;

    assign abort = !rx_en || (mode_all != mode_d);
    assign last  = tick && (cnt == CW'(OSR - 1));
    assign midp  = tick && (cnt == CW'(MID - 1));
    assign busy  = (state != RX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:  if (fall) nxt = RX_START;
                RX_START: if (midp) nxt = maj ? RX_IDLE : RX_DATA;
                RX_DATA:  if (last && bitn == BW'(DW - 1)) nxt = RX_NINTH;
                RX_NINTH: if (last) nxt = RX_STOP;
                RX_STOP:  if (last) nxt = RX_IDLE;
                default:  nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bitn     <= '0;
            mode_d   <= 1'b0;
            shreg    <= '0;
            nine     <= 1'b0;
            stop_bit <= 1'b1;
            done     <= 1'b0;
        end else begin
            mode_d <= mode_all;
            done   <= 1'b0;
            if (nxt != state)   cnt <= '0;
            else if (last)      cnt <= '0;
            else if (tick)      cnt <= cnt + 1'b1;
            if (state == RX_IDLE) bitn <= '0;
            if (state == RX_DATA && last) begin
                shreg <= {maj, shreg[DW-1:1]};
                bitn  <= bitn + 1'b1;
            end
            if (state == RX_NINTH && last) nine <= maj;
            if (state == RX_STOP && last && !abort) begin
                stop_bit <= maj;
                done     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mprx_flags.sv
// Acceptance filter, parity evaluation and host-visible result registers.
module mprx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] shreg,
    input  logic          nine,
    input  logic          stop_bit,
    input  logic          mode_all,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          rx_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_flag,
    output logic          frame_err,
    output logic          overrun
);
    logic accept, perr;

    assign accept = done && (mode_all || nine);
    assign perr   = (^shreg) ^ nine ^ par_odd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_flag   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (rx_clr) begin
                rx_flag <= 1'b0;
                overrun <= 1'b0;
            end
            if (accept) begin
                rx_data   <= shreg;
                rx_bit9   <= (mode_all && par_en) ? perr : nine;
                frame_err <= ~stop_bit;
                rx_flag   <= 1'b1;
                if (rx_flag && !rx_clr) overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          rx_en,
    input  logic          mode_all,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          rx_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_flag,
    output logic          frame_err,
    output logic          overrun
);
    logic          fall, maj, busy, done, nine, stop_bit;
    logic [DW-1:0] shreg;

    mprx_sampler #(.STAGES(2), .VOTES(3)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .fall(fall), .maj(maj)
    );

    mprx_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall), .maj(maj),
        .rx_en(rx_en), .mode_all(mode_all), .busy(busy), .done(done),
        .shreg(shreg), .nine(nine), .stop_bit(stop_bit)
    );

    mprx_flags #(.DW(DW)) u_flags (
        .clk(clk), .rst_n(rst_n), .done(done), .shreg(shreg), .nine(nine),
        .stop_bit(stop_bit), .mode_all(mode_all), .par_en(par_en),
        .par_odd(par_odd), .rx_clr(rx_clr), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_flag(rx_flag), .frame_err(frame_err),
        .overrun(overrun)
    );
endmodule

// File: rtl/mprx_chk.sv
module mprx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          mode_all,
    input logic          rx_clr,
    input logic          rx_flag,
    input logic          overrun,
    input logic [DW-1:0] rx_data,
    input logic          busy,
    input logic          done,
    input logic          nine
);
    // R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(done));

    // R4
    filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_all && !nine) |=> $stable(rx_data));

    // R8
    en_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !busy);

    // R9
    mode_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_all != $past(mode_all))) |=> !busy);

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_all || nine) && rx_flag && !rx_clr) |=> overrun);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !done) |=> (!rx_flag && !overrun));
endmodule

bind mp_uart_rx mprx_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_all(mode_all),
    .rx_clr(rx_clr), .rx_flag(rx_flag), .overrun(overrun),
    .rx_data(rx_data), .busy(busy), .done(done), .nine(nine)
);

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;
    localparam int TDIV = 4;
    localparam int BITC = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       mode_all = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rx_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_flag, frame_err, overrun;
    logic [1:0] div = '0;

    int ncmp = 0;
    int nerr = 0;
    logic [7:0] lastd = 8'h00;
    logic       lastb = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        div  <= div + 1'b1;
        tick <= (div == 2'(TDIV - 1));
    end

    mp_uart_rx u_mp_uart_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .mode_all(mode_all), .par_en(par_en), .par_odd(par_odd),
        .rx_clr(rx_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_flag(rx_flag), .frame_err(frame_err), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        ncmp++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic stp);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        hold_bit(b9);
        hold_bit(stp);
        rxd = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic clear_flag();
        rx_clr = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] pats [5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h01; pats[4] = 8'h80;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 flag", {8'h0, rx_flag}, 9'h0);
        chk("R1 overrun", {8'h0, overrun}, 9'h0);
        chk("R1 frame_err", {8'h0, frame_err}, 9'h0);
        chk("R1 data", {1'b0, rx_data}, 9'h0);
        chk("R1 bit9", {8'h0, rx_bit9}, 9'h0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (10) @(negedge clk);

        // Sweep: R2 R4 R5 R6
        for (int m = 0; m < 2; m++)
        for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
        for (int b = 0; b < 2; b++)
        for (int k = 0; k < 5; k++) begin
            logic acc, eb;
            mode_all = m[0]; par_en = pe[0]; par_odd = po[0];
            repeat (4) @(negedge clk);
            send(pats[k], b[0], 1'b1);
            acc = m[0] | b[0];
            eb  = (m[0] & pe[0]) ? ((^pats[k]) ^ b[0] ^ po[0]) : b[0];
            if (acc) begin lastd = pats[k]; lastb = eb; end
            chk(acc ? "R5 flag kept" : "R4 flag dropped", {8'h0, rx_flag}, {8'h0, acc});
            chk("R2 data", {1'b0, rx_data}, {1'b0, lastd});
            chk((m == 1 && pe == 1) ? "R6 parity status" : "R4 R5 ninth bit",
                {8'h0, rx_bit9}, {8'h0, lastb});
            chk("R7 no framing error", {8'h0, frame_err}, 9'h0);
            clear_flag();
        end

        // R7 framing error
        mode_all = 1'b1; par_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h5A, 1'b0, 1'b0);
        chk("R7 frame_err set", {8'h0, frame_err}, 9'h1);
        chk("R7 flag", {8'h0, rx_flag}, 9'h1);
        clear_flag();
        send(8'h3C, 1'b1, 1'b1);
        chk("R7 frame_err cleared", {8'h0, frame_err}, 9'h0);
        lastd = 8'h3C; lastb = 1'b1;
        clear_flag();

        // R10 hold, overrun, clear
        send(8'h11, 1'b0, 1'b1);
        repeat (500) @(negedge clk);
        chk("R10 flag held", {8'h0, rx_flag}, 9'h1);
        chk("R10 no overrun yet", {8'h0, overrun}, 9'h0);
        send(8'h22, 1'b1, 1'b1);
        lastd = 8'h22; lastb = 1'b1;
        chk("R10 overrun", {8'h0, overrun}, 9'h1);
        chk("R10 newest data", {1'b0, rx_data}, 9'h022);
        clear_flag();
        chk("R10 flag cleared", {8'h0, rx_flag}, 9'h0);
        chk("R10 overrun cleared", {8'h0, overrun}, 9'h0);

        // R3 false start
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (1200) @(negedge clk);
        chk("R3 no flag on glitch", {8'h0, rx_flag}, 9'h0);
        send(8'hC3, 1'b0, 1'b1);
        lastd = 8'hC3; lastb = 1'b0;
        chk("R3 recovers", {1'b0, rx_data}, 9'h0C3);
        clear_flag();

        // R8 blocked while disabled
        rx_en = 1'b0;
        send(8'h00, 1'b1, 1'b1);
        chk("R8 blocked flag", {8'h0, rx_flag}, 9'h0);
        chk("R8 blocked data", {1'b0, rx_data}, {1'b0, lastd});
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R8 abort mid-frame
        fork
            send(8'hFF, 1'b1, 1'b1);
            begin
                repeat (4 * BITC) @(negedge clk);
                rx_en = 1'b0;
                repeat (2) @(negedge clk);
                rx_en = 1'b1;
            end
        join
        chk("R8 aborted flag", {8'h0, rx_flag}, 9'h0);
        chk("R8 aborted data", {1'b0, rx_data}, {1'b0, lastd});

        // R9 mode change aborts
        fork
            send(8'hFF, 1'b1, 1'b1);
            begin
                repeat (4 * BITC) @(negedge clk);
                mode_all = 1'b0;
            end
        join
        chk("R9 aborted flag", {8'h0, rx_flag}, 9'h0);
        chk("R9 aborted data", {1'b0, rx_data}, {1'b0, lastd});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        ncmp++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end
endmodule